// File: doc/BRIEF.md
# Banked event interrupt multiplexer

This block gathers up to 96 single-cycle hardware event strobes into three 32-bit pending banks and folds them onto three level-sensitive interrupt lines, `irq_a`, `irq_b` and `irq_c`. Each line has its own set of three enable words, one per bank, so the same pending state can be steered to any mix of the three lines. In a larger system, `irq_a`, `irq_b` and `irq_c` are meant to drive the inputs of an interrupt controller at priority levels 13, 11 and 9.

Events arrive on a valid/ready stream carrying a 7-bit event number. The upper two bits of the number pick the bank and the lower five bits pick the bit within that bank. The block never applies back-pressure: `evt_ready` is held high, and an event is taken on every clock edge at which `evt_valid` is high. Software reaches the pending and enable words through a simple word-addressed register port. Writing a one to a pending bit clears that bit. A separate hardware clear port drops one pending bit, chosen by event number. One bit, bank 1 bit 0, is held by hardware: software writes cannot clear it, and only the hardware clear port can.

Top module: `evt_irq_mux`

## Requirements
- R1: When `evt_valid` is high, event number n (with n[6:5] < 3) sets bit n[4:0] of pending bank n[6:5] at the next clock edge.
- R2: An event whose number has n[6:5] = 3 (n >= 96) changes no pending bit.
- R3: Each of `irq_a`, `irq_b` and `irq_c` is high exactly when at least one pending bit, in any bank, is also set in that line's enable word for the same bank. The outputs follow the registers with no extra delay, so a change to an enable word acts in the cycle after its write edge, including on bits that are already pending.
- R4: The enable words sit at word addresses 3 to 11. Line A uses addresses 3, 4 and 5, line B uses 6, 7 and 8, and line C uses 9, 10 and 11, each group in the order bank 0, bank 1, bank 2.
- R5: A write to pending word addresses 0 to 2 (banks 0 to 2) clears every bit written as 1 and leaves every bit written as 0 unchanged. No pending bit falls in a cycle with no register write and no hardware clear.
- R6: Bank 1 bit 0 (event 32) is never cleared by a software write to address 1.
- R7: When `clr_valid` is high, `clr_num` clears the pending bit it names, decoded in the same way as R1. A `clr_num` of 96 or more has no effect.
- R8: When the same pending bit is set by an event and cleared (by software or by the hardware clear port) at the same edge, the bit ends set.
- R9: `reg_rdata` returns, without delay, the stored value of the word at `reg_addr`. Addresses 12 to 15 read as 0, and writes to them change nothing.
- R10: While `rst_n` is low, all pending and enable words are 0 and all three interrupt lines are low.
- R11: `evt_ready` is always 1. Events sent on consecutive cycles are all recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_valid | input | 1 | An event number is presented |
| evt_ready | output | 1 | Always high; the block never stalls an event |
| evt_num | input | 7 | Event number: [6:5] bank, [4:0] bit |
| clr_valid | input | 1 | Hardware clear request |
| clr_num | input | 7 | Event number of the bit to clear |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address (0-2 pending, 3-11 enables) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_a | output | 1 | Interrupt line A (level 13) |
| irq_b | output | 1 | Interrupt line B (level 11) |
| irq_c | output | 1 | Interrupt line C (level 9) |

## Verification
Every stimulus (an event, a hardware clear or a register write) lands at the clock edge that samples it, and the result shows at the ports one register stage later. The interrupt lines and read data are therefore due at the falling edge that follows that rising edge. The bench drives its inputs just after a falling edge, updates its reference model at the rising edge, and compares all three lines and the read word at the next falling edge. This timing also covers enable changes acting on bits that are already pending and the set-over-clear collisions. Read data is combinational, so a directed read changes only `reg_addr` and compares a moment later, with no clock edge in between.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  // kind of register selected by the word address
  typedef enum logic [1:0] {
    RK_PEND = 2'd0,
    RK_MASK = 2'd1,
    RK_HOLE = 2'd2
  } reg_kind_e;
endpackage

// File: rtl/evt_decode.sv
// Turns a packed event number into a one-hot bit map per bank.
module evt_decode #(
  parameter int BANKS = 3,
  parameter int BITS  = 32,
  localparam int SELW = $clog2(BANKS),
  localparam int BITW = $clog2(BITS),
  localparam int NUMW = SELW + BITW
) (
  input  logic                        valid,
  input  logic [NUMW-1:0]             num,
  output logic [BANKS-1:0][BITS-1:0]  hit
);
  logic [SELW-1:0] bank_sel;
  logic [BITW-1:0] bit_sel;

  assign bank_sel = num[NUMW-1:BITW];
  assign bit_sel  = num[BITW-1:0];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic match;
    assign match  = valid && (bank_sel == SELW'(b));
    assign hit[b] = match ? (BITS'(1) << bit_sel) : '0;
  end
endmodule

// File: rtl/pend_bank.sv
// One pending word: hardware set beats every clear, one bit may be guarded
// against software clears.
module pend_bank #(
  parameter int BITS     = 32,
  parameter bit PROT_EN  = 1'b0,
  parameter int PROT_BIT = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] set_vec,
  input  logic            sw_wr,
  input  logic [BITS-1:0] sw_data,
  input  logic [BITS-1:0] hw_clr,
  output logic [BITS-1:0] pend
);
  localparam logic [BITS-1:0] KEEP = PROT_EN ? (BITS'(1) << PROT_BIT) : '0;

  logic [BITS-1:0] sw_clr;
  logic [BITS-1:0] pend_nxt;

  assign sw_clr   = sw_wr ? (sw_data & ~KEEP) : '0;
  assign pend_nxt = (pend & ~sw_clr & ~hw_clr) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nxt;
  end
endmodule

// File: rtl/irq_route.sv
// Enable words of one interrupt line and the reduction onto that line.
module irq_route #(
  parameter int BANKS = 3,
  parameter int BITS  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [BANKS-1:0]           wr_sel,
  input  logic [BITS-1:0]            wdata,
  input  logic [BANKS-1:0][BITS-1:0] pend,
  output logic [BANKS-1:0][BITS-1:0] mask,
  output logic                       irq
);
  logic [BANKS-1:0] bank_hit;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [BITS-1:0] en_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q <= '0;
      else if (wr_sel[b]) en_q <= wdata;
    end
    assign mask[b]     = en_q;
    assign bank_hit[b] = |(pend[b] & en_q);
  end

  assign irq = |bank_hit;
endmodule

// File: rtl/reg_decode.sv
// Word address decode: pending words first, then the enable words grouped
// by line, each group in bank order.
module reg_decode
  import evt_irq_pkg::*;
#(
  parameter int BANKS  = 3,
  parameter int OUTS   = 3,
  parameter int ADDR_W = 4,
  localparam int SELW  = $clog2(BANKS),
  localparam int OUTW  = $clog2(OUTS)
) (
  input  logic                        wen,
  input  logic [ADDR_W-1:0]           addr,
  output logic [BANKS-1:0]            pend_wr,
  output logic [OUTS-1:0][BANKS-1:0]  mask_wr,
  output reg_kind_e                   kind,
  output logic [SELW-1:0]             rd_bank,
  output logic [OUTW-1:0]             rd_out
);
  always_comb begin
    kind    = RK_HOLE;
    rd_bank = '0;
    rd_out  = '0;
    pend_wr = '0;
    mask_wr = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (addr == ADDR_W'(b)) begin
        kind       = RK_PEND;
        rd_bank    = SELW'(b);
        pend_wr[b] = wen;
      end
    end
    for (int o = 0; o < OUTS; o++) begin
      for (int b = 0; b < BANKS; b++) begin
        if (addr == ADDR_W'(BANKS + o * BANKS + b)) begin
          kind          = RK_MASK;
          rd_bank       = SELW'(b);
          rd_out        = OUTW'(o);
          mask_wr[o][b] = wen;
        end
      end
    end
  end
endmodule

// File: rtl/evt_irq_mux.sv
module evt_irq_mux
  import evt_irq_pkg::*;
#(
  parameter int BANKS     = 3,
  parameter int BITS      = 32,
  parameter int ADDR_W    = 4,
  parameter int PROT_BANK = 1,
  parameter int PROT_BIT  = 0,
  localparam int NUMW     = $clog2(BANKS) + $clog2(BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [NUMW-1:0]   evt_num,
  input  logic              clr_valid,
  input  logic [NUMW-1:0]   clr_num,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BITS-1:0]   reg_wdata,
  output logic [BITS-1:0]   reg_rdata,
  output logic              irq_a,
  output logic              irq_b,
  output logic              irq_c
);
  localparam int OUTS = 3;
  localparam int SELW = $clog2(BANKS);
  localparam int OUTW = $clog2(OUTS);

  logic [BANKS-1:0][BITS-1:0]            evt_hit;
  logic [BANKS-1:0][BITS-1:0]            clr_hit;
  logic [BANKS-1:0][BITS-1:0]            pend_q;
  logic [BANKS*BITS-1:0]                 pend_flat;
  logic [OUTS-1:0][BANKS-1:0][BITS-1:0]  mask_all;
  logic [OUTS-1:0]                       irq_vec;
  logic [BANKS-1:0]                      pend_wr;
  logic [OUTS-1:0][BANKS-1:0]            mask_wr;
  reg_kind_e                             kind;
  logic [SELW-1:0]                       rd_bank;
  logic [OUTW-1:0]                       rd_out;

  assign evt_ready = 1'b1;

  evt_decode #(.BANKS(BANKS), .BITS(BITS)) u_evt_dec (
    .valid (evt_valid),
    .num   (evt_num),
    .hit   (evt_hit)
  );

  evt_decode #(.BANKS(BANKS), .BITS(BITS)) u_clr_dec (
    .valid (clr_valid),
    .num   (clr_num),
    .hit   (clr_hit)
  );

  reg_decode #(.BANKS(BANKS), .OUTS(OUTS), .ADDR_W(ADDR_W)) u_rdec (
    .wen     (reg_wen),
    .addr    (reg_addr),
    .pend_wr (pend_wr),
    .mask_wr (mask_wr),
    .kind    (kind),
    .rd_bank (rd_bank),
    .rd_out  (rd_out)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_pend
    pend_bank #(
      .BITS     (BITS),
      .PROT_EN  (b == PROT_BANK),
      .PROT_BIT (PROT_BIT)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (evt_hit[b]),
      .sw_wr   (pend_wr[b]),
      .sw_data (reg_wdata),
      .hw_clr  (clr_hit[b]),
      .pend    (pend_q[b])
    );
  end

  assign pend_flat = pend_q;

  for (genvar o = 0; o < OUTS; o++) begin : g_line
    irq_route #(.BANKS(BANKS), .BITS(BITS)) u_route (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_sel (mask_wr[o]),
      .wdata  (reg_wdata),
      .pend   (pend_q),
      .mask   (mask_all[o]),
      .irq    (irq_vec[o])
    );
  end

  assign irq_a = irq_vec[0];
  assign irq_b = irq_vec[1];
  assign irq_c = irq_vec[2];

  always_comb begin
    case (kind)
      RK_PEND: reg_rdata = pend_flat[rd_bank * BITS +: BITS];
      RK_MASK: reg_rdata = mask_all[rd_out][rd_bank];
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
  parameter int TOTAL     = 96,
  parameter int NUMW      = 7,
  parameter int ADDR_W    = 4,
  parameter int BITS      = 32,
  parameter int PROT_IDX  = 32,
  parameter int PROT_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic [NUMW-1:0]   evt_num,
  input logic              clr_valid,
  input logic [NUMW-1:0]   clr_num,
  input logic              reg_wen,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [BITS-1:0]   reg_wdata,
  input logic [TOTAL-1:0]  pend_flat,
  input logic              irq_a,
  input logic              irq_b,
  input logic              irq_c
);
  logic quiet;
  assign quiet = !reg_wen && !clr_valid;

  assert_evt_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_num < NUMW'(TOTAL)) |=> pend_flat[$past(evt_num)]);

  assert_bank3_noeffect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_num >= NUMW'(TOTAL) && quiet) |=> $stable(pend_flat));

  assert_irq_a_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a && quiet) |=> irq_a);
  assert_irq_b_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_b && quiet) |=> irq_b);
  assert_irq_c_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_c && quiet) |=> irq_c);

  assert_no_silent_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> ((pend_flat & $past(pend_flat)) == $past(pend_flat)));

  assert_guarded_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == ADDR_W'(PROT_ADDR) && pend_flat[PROT_IDX]
     && !(clr_valid && clr_num == NUMW'(PROT_IDX))) |=> pend_flat[PROT_IDX]);

  assert_hw_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && clr_num < NUMW'(TOTAL) && !(evt_valid && evt_num == clr_num))
    |=> !pend_flat[$past(clr_num)]);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && clr_valid && evt_num == clr_num && evt_num < NUMW'(TOTAL))
    |=> pend_flat[$past(evt_num)]);

  // reg_wdata is part of the observed port set; write effects are covered above
  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;
endmodule

bind evt_irq_mux evt_irq_chk #(
  .TOTAL     (BANKS * BITS),
  .NUMW      (NUMW),
  .ADDR_W    (ADDR_W),
  .BITS      (BITS),
  .PROT_IDX  (PROT_BANK * BITS + PROT_BIT),
  .PROT_ADDR (PROT_BANK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_valid (evt_valid),
  .evt_num   (evt_num),
  .clr_valid (clr_valid),
  .clr_num   (clr_num),
  .reg_wen   (reg_wen),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .pend_flat (pend_flat),
  .irq_a     (irq_a),
  .irq_b     (irq_b),
  .irq_c     (irq_c)
);

// File: tb/sim_evt_irq_mux.sv
`timescale 1ns/1ps
module sim_evt_irq_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic        evt_ready;
  logic [6:0]  evt_num = '0;
  logic        clr_valid = 1'b0;
  logic [6:0]  clr_num = '0;
  logic        reg_wen = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_a, irq_b, irq_c;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] m_pend [3];
  logic [31:0] m_mask [3][3];

  always #10 clk = ~clk;

  evt_irq_mux u0 (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_num(evt_num),
    .clr_valid(clr_valid), .clr_num(clr_num),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq_a(irq_a), .irq_b(irq_b), .irq_c(irq_c)
  );

  function automatic logic [31:0] exp_rd(int a);
    if (a < 3)       return m_pend[a];
    else if (a < 12) return m_mask[(a - 3) / 3][(a - 3) % 3];
    else             return 32'h0;
  endfunction

  function automatic logic exp_irq(int o);
    logic r = 1'b0;
    for (int b = 0; b < 3; b++) r |= |(m_pend[b] & m_mask[o][b]);
    return r;
  endfunction

  task automatic chk32(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    int a = int'(reg_addr);
    if (reg_wen && a < 3) begin
      logic [31:0] c = reg_wdata;
      if (a == 1) c[0] = 1'b0;
      m_pend[a] &= ~c;
    end
    if (reg_wen && a >= 3 && a < 12) m_mask[(a - 3) / 3][(a - 3) % 3] = reg_wdata;
    if (clr_valid && clr_num < 7'd96) m_pend[clr_num / 32][clr_num % 32] = 1'b0;
    if (evt_valid && evt_num < 7'd96) m_pend[evt_num / 32][evt_num % 32] = 1'b1;
  endtask

  // one clock: model follows the edge, outputs compared at the next falling edge
  task automatic tick();
    if (evt_valid) chk32("R11 ready", {31'b0, evt_ready}, 32'h1);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk32("R3 irq_a", {31'b0, irq_a}, {31'b0, exp_irq(0)});
    chk32("R3 irq_b", {31'b0, irq_b}, {31'b0, exp_irq(1)});
    chk32("R3 irq_c", {31'b0, irq_c}, {31'b0, exp_irq(2)});
    chk32("R9 rdata", reg_rdata, exp_rd(int'(reg_addr)));
    evt_valid = 1'b0;
    clr_valid = 1'b0;
    reg_wen   = 1'b0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_wen = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    tick();
  endtask

  task automatic ev(int n);
    evt_valid = 1'b1; evt_num = 7'(n);
    tick();
  endtask

  task automatic hclr(int n);
    clr_valid = 1'b1; clr_num = 7'(n);
    tick();
  endtask

  task automatic rd(string req, int a, logic [31:0] exp);
    reg_addr = 4'(a);
    #1;
    chk32(req, reg_rdata, exp);
  endtask

  task automatic line(string req, logic act, logic exp);
    chk32(req, {31'b0, act}, {31'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 3; b++) begin
      m_pend[b] = '0;
      for (int o = 0; o < 3; o++) m_mask[o][b] = '0;
    end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R10: reset state
    line("R10 irq_a", irq_a, 1'b0);
    line("R10 irq_b", irq_b, 1'b0);
    line("R10 irq_c", irq_c, 1'b0);
    for (int a = 0; a < 16; a++) rd("R10 reset word", a, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 + R4 + R3: line A, bank 0 bit 5
    wr(3, 32'h0000_0020);
    ev(5);
    rd("R1 bank0 bit5", 0, 32'h0000_0020);
    line("R3 line A on", irq_a, 1'b1);
    line("R4 line B off", irq_b, 1'b0);
    // R4: line B bank 2 word, event 95
    wr(8, 32'h8000_0000);
    ev(95);
    line("R4 line B on", irq_b, 1'b1);
    rd("R1 bank2 bit31", 2, 32'h8000_0000);
    // R4: line C bank 1 word, event 33
    wr(10, 32'h0000_0002);
    ev(33);
    line("R4 line C on", irq_c, 1'b1);
    // R3: enable change on already-pending bit acts at once
    wr(3, 32'h0);
    line("R3 mask off drops A", irq_a, 1'b0);
    wr(3, 32'h0000_0020);
    line("R3 mask on raises A", irq_a, 1'b1);
    // R3: line stays while any bank still hits
    wr(5, 32'h8000_0000);
    wr(0, 32'h0000_0020);
    line("R3 A held by bank2", irq_a, 1'b1);
    // R5: zeros leave bits, ones clear
    ev(7);
    wr(2, 32'h0);
    rd("R5 zero write keeps", 2, 32'h8000_0000);
    wr(2, 32'h8000_0000);
    line("R3 A drops when all clear", irq_a, 1'b0);
    rd("R5 one write clears", 2, 32'h0);
    rd("R5 bank0 bit7 kept", 0, 32'h0000_0080);
    // R6: guarded bit
    ev(32);
    wr(1, 32'hFFFF_FFFF);
    rd("R6 guarded bit stays", 1, 32'h0000_0001);
    hclr(32);
    rd("R7 hw clear guarded bit", 1, 32'h0);
    // R7: out-of-range clear ignored, then real clear
    ev(70);
    hclr(100);
    rd("R7 bank3 clear ignored", 2, 32'h0000_0040);
    hclr(70);
    rd("R7 hw clear", 2, 32'h0);
    // R8: set beats clears in the same cycle
    evt_valid = 1'b1; evt_num = 7'd40;
    reg_wen = 1'b1; reg_addr = 4'd1; reg_wdata = 32'h0000_0100;
    tick();
    rd("R8 set beats sw clear", 1, 32'h0000_0100);
    evt_valid = 1'b1; evt_num = 7'd41;
    clr_valid = 1'b1; clr_num = 7'd41;
    tick();
    rd("R8 set beats hw clear", 1, 32'h0000_0300);
    // R2: bank 3 events do nothing
    ev(97);
    ev(127);
    rd("R2 bank0", 0, 32'h0000_0080);
    rd("R2 bank1", 1, 32'h0000_0300);
    rd("R2 bank2", 2, 32'h0);
    // R9: hole writes ignored, enables read back
    wr(13, 32'hFFFF_FFFF);
    rd("R9 hole reads zero", 13, 32'h0);
    rd("R9 enable readback", 10, 32'h0000_0002);
    rd("R9 enable readback B", 8, 32'h8000_0000);
    // R11: back-to-back events
    for (int i = 0; i < 8; i++) begin
      evt_valid = 1'b1; evt_num = 7'(48 + i);
      tick();
    end
    rd("R11 back to back", 1, 32'h00FF_0300);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      evt_valid = ($urandom % 2) == 0;
      evt_num   = 7'($urandom % 104);
      clr_valid = ($urandom % 4) == 0;
      clr_num   = 7'($urandom % 104);
      reg_wen   = ($urandom % 3) == 0;
      reg_addr  = 4'($urandom % 16);
      reg_wdata = $urandom & $urandom & $urandom;
      tick();
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule